// File: doc/BRIEF.md
# Indexed-Element Fused Multiply-Add Operand Preparer

This block sits in front of a floating-point fused multiply-add datapath. It accepts a 32-bit instruction word and recognises the four forms of the by-element multiply-accumulate and multiply-subtract instruction: scalar or vector, each in half precision or in single/double precision. It classifies each word as usable, undefined or not recognised. For usable words it works out the element width, the lane count, the element index and the three register numbers.

One registered cycle after a word is accepted, the block presents the three register numbers on a read port, and the register values come back in the same cycle. The block then builds the operand bundle. The chosen element of the index register is broadcast to every active lane. Each active lane of the first operand has its sign bit flipped when the word asks for subtraction. The accumulator lanes are copied from the destination register. Lanes above the data size are cleared in all three operands. The bundle is registered and handed on with a valid/ready handshake.

Top module: `idx_fma_prep`

## Requirements
- R1: A word is recognised only if bit 31 is 0, bits 15, 13 and 10 are 0, bit 12 is 1, bits 23:22 are not 01, and either bits 30:24 are 1011111 (scalar) or bits 29:24 are 001111 (vector, bit 30 giving the width Q). Any other word raises `out_nomatch` and never `out_undef` or `out_valid`.
- R2: A recognised half-precision word (bits 23:22 = 00) raises `out_undef` when `fp16_en` is 0.
- R3: A recognised single/double word (bit 23 = 1, bit 22 = sz) is undefined when sz = 1 and bit 21 = 1. A vector single/double word with sz = 1 and Q = 0 is also undefined. In both cases `out_undef` rises and `out_valid` does not.
- R4: `rf_idx_n` is bits 9:5 and `out_dst` is bits 4:0. `rf_idx_m` is bits 19:16 zero-extended for half precision, and bit 20 followed by bits 19:16 otherwise.
- R5: The broadcast element index is {bit 11, bit 21, bit 20} for half precision, {bit 11, bit 21} for single precision and bit 11 for double precision. Every active lane of `out_mul_b` carries that element of the index register.
- R6: `out_esz` is 0, 1 or 2 for 16-, 32- or 64-bit elements. `out_lanes` is 1 for scalar forms. For vector forms it is 128 (Q = 1) or 64 (Q = 0) divided by the element width.
- R7: When bit 14 is 1, each active lane of `out_mul_a` is the first-operand lane with only its top bit inverted. When bit 14 is 0 the lane is unchanged.
- R8: All three operand buses are zero in every lane at or above `out_lanes`.
- R9: Lane e of `out_acc` equals lane e of the destination register.
- R10: With an idle pipeline and `out_ready` high, a usable word accepted at edge k gives `out_valid` for the cycle after edge k+1. A faulty word raises its flag for exactly the cycle after edge k.
- R11: While `out_valid` is high and `out_ready` is low, every output stays unchanged. Once a second word is held behind it, `in_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fp16_en | input | 1 | Half-precision forms permitted |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Instruction word can be taken |
| in_instr | input | 32 | Instruction word |
| rf_idx_n | output | 5 | Read address, first operand |
| rf_idx_m | output | 5 | Read address, index register |
| rf_idx_d | output | 5 | Read address, accumulator |
| rf_val_n | input | 128 | Read data, first operand |
| rf_val_m | input | 128 | Read data, index register |
| rf_val_d | input | 128 | Read data, accumulator |
| out_valid | output | 1 | Operand bundle present |
| out_ready | input | 1 | Consumer takes the bundle |
| out_lanes | output | 4 | Active lane count |
| out_esz | output | 2 | Element size code |
| out_dst | output | 5 | Destination register number |
| out_mul_a | output | 128 | First multiplicand lanes, sign-adjusted |
| out_mul_b | output | 128 | Broadcast multiplicand lanes |
| out_acc | output | 128 | Accumulator lanes |
| out_undef | output | 1 | Recognised but undefined word |
| out_nomatch | output | 1 | Unrecognised word |

## Verification
The hardest state to reach is a second word parked in the decode stage behind a bundle that the consumer refuses. The bench gets there by holding `out_ready` low, sending one usable word, letting it reach the output, and then sending another. It then checks that the first bundle stays put and `in_ready` stays low until the consumer releases it. The bench's register model gives every 16-bit chunk of every register a distinct value with a clear top bit. Because of this, a wrong element index, a wrong register number or a wrong sign inversion each changes the bundle.

// File: rtl/idx_fma_pkg.sv
`timescale 1ns/1ps
package idx_fma_pkg;
  parameter int unsigned VREG_W   = 128;
  parameter int unsigned RIDX_W   = 5;
  parameter int unsigned IWORD_W  = 32;
  parameter int unsigned MIN_EW   = 16;
  localparam int unsigned MIN_EW_LOG2 = $clog2(MIN_EW);
  localparam int unsigned MAX_LANES   = VREG_W / MIN_EW;
  localparam int unsigned LANE_CW     = $clog2(MAX_LANES) + 1;
  localparam int unsigned NUM_EW      = 3;
  localparam int unsigned IDX_W       = $clog2(MAX_LANES);

  typedef enum logic [1:0] {
    ESZ_16 = 2'd0,
    ESZ_32 = 2'd1,
    ESZ_64 = 2'd2
  } esz_e;

  typedef struct packed {
    logic [RIDX_W-1:0]  dst;
    logic [RIDX_W-1:0]  src_n;
    logic [RIDX_W-1:0]  src_m;
    esz_e               esz;
    logic [LANE_CW-1:0] lanes;
    logic [IDX_W-1:0]   idx;
    logic               neg;
    logic               undef;
    logic               nomatch;
  } dec_t;
endpackage

// File: rtl/idx_fma_decode.sv
`timescale 1ns/1ps
module idx_fma_decode
  import idx_fma_pkg::*;
(
  input  logic [IWORD_W-1:0] word,
  input  logic               fp16_en,
  output dec_t               dec
);
  logic is_scalar, is_vector, fixed_ok, prec_ok, hit;
  logic half, sz, q, hb, lb, mb, bad;

  assign is_scalar = !word[31] && (word[30:24] == 7'b1011111);
  assign is_vector = !word[31] && (word[29:24] == 6'b001111);
  assign fixed_ok  = !word[15] && !word[13] && word[12] && !word[10];
  assign prec_ok   = (word[23:22] != 2'b01);
  assign hit       = (is_scalar || is_vector) && fixed_ok && prec_ok;

  assign half = (word[23:22] == 2'b00);
  assign sz   = word[22];
  assign q    = word[30];
  assign hb   = word[11];
  assign lb   = word[21];
  assign mb   = word[20];

  always_comb begin
    int dsz;
    dec       = '0;
    dec.dst   = word[4:0];
    dec.src_n = word[9:5];
    dec.neg   = word[14];
    bad       = 1'b0;
    if (half) begin
      dec.esz   = ESZ_16;
      dec.idx   = {hb, lb, mb};
      dec.src_m = {1'b0, word[19:16]};
      bad       = !fp16_en;
    end else begin
      dec.esz   = sz ? ESZ_64 : ESZ_32;
      dec.src_m = {mb, word[19:16]};
      if (!sz) dec.idx = {1'b0, hb, lb};
      else     dec.idx = {2'b00, hb};
      bad = (sz && lb) || (is_vector && sz && !q);
    end
    dsz = q ? int'(VREG_W) : int'(VREG_W / 2);
    if (is_scalar) dec.lanes = LANE_CW'(1);
    else           dec.lanes = LANE_CW'(dsz >> (MIN_EW_LOG2 + int'(dec.esz)));
    dec.nomatch = !hit;
    dec.undef   = hit && bad;
  end
endmodule

// File: rtl/idx_fma_lanes.sv
`timescale 1ns/1ps
module idx_fma_lanes
  import idx_fma_pkg::*;
#(
  parameter int unsigned EW = 16,
  localparam int unsigned NL = VREG_W / EW,
  localparam int unsigned IW = $clog2(NL)
)(
  input  logic [VREG_W-1:0]  rn_v,
  input  logic [VREG_W-1:0]  rm_v,
  input  logic [VREG_W-1:0]  rd_v,
  input  logic [IW-1:0]      idx,
  input  logic [LANE_CW-1:0] lanes,
  input  logic               neg,
  output logic [VREG_W-1:0]  mul_a,
  output logic [VREG_W-1:0]  mul_b,
  output logic [VREG_W-1:0]  acc
);
  logic [EW-1:0] bcast;
  assign bcast = rm_v[int'(idx)*EW +: EW];

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic on;
    assign on = (LANE_CW'(g) < lanes);
    assign mul_a[g*EW +: EW] = on ? {rn_v[g*EW+EW-1] ^ neg, rn_v[g*EW +: EW-1]} : '0;
    assign mul_b[g*EW +: EW] = on ? bcast : '0;
    assign acc[g*EW +: EW]   = on ? rd_v[g*EW +: EW] : '0;
  end
endmodule

// File: rtl/idx_fma_prep.sv
`timescale 1ns/1ps
module idx_fma_prep
  import idx_fma_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               fp16_en,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [IWORD_W-1:0] in_instr,
  output logic [RIDX_W-1:0]  rf_idx_n,
  output logic [RIDX_W-1:0]  rf_idx_m,
  output logic [RIDX_W-1:0]  rf_idx_d,
  input  logic [VREG_W-1:0]  rf_val_n,
  input  logic [VREG_W-1:0]  rf_val_m,
  input  logic [VREG_W-1:0]  rf_val_d,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [LANE_CW-1:0] out_lanes,
  output logic [1:0]         out_esz,
  output logic [RIDX_W-1:0]  out_dst,
  output logic [VREG_W-1:0]  out_mul_a,
  output logic [VREG_W-1:0]  out_mul_b,
  output logic [VREG_W-1:0]  out_acc,
  output logic               out_undef,
  output logic               out_nomatch
);
  dec_t dec_now, s1_dec;
  logic s1_valid, s1_bad, s1_adv, s2_free;

  idx_fma_decode u_dec (
    .word    (in_instr),
    .fp16_en (fp16_en),
    .dec     (dec_now)
  );

  assign s2_free  = !out_valid || out_ready;
  assign s1_bad   = s1_dec.undef || s1_dec.nomatch;
  assign s1_adv   = s1_valid && (s1_bad || s2_free);
  assign in_ready = !s1_valid || s1_adv;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_dec   <= '0;
    end else if (in_valid && in_ready) begin
      s1_valid <= 1'b1;
      s1_dec   <= dec_now;
    end else if (s1_adv) begin
      s1_valid <= 1'b0;
    end
  end

  assign rf_idx_n    = s1_dec.src_n;
  assign rf_idx_m    = s1_dec.src_m;
  assign rf_idx_d    = s1_dec.dst;
  assign out_undef   = s1_valid && s1_dec.undef;
  assign out_nomatch = s1_valid && s1_dec.nomatch;

  logic [VREG_W-1:0] sh_a [NUM_EW];
  logic [VREG_W-1:0] sh_b [NUM_EW];
  logic [VREG_W-1:0] sh_c [NUM_EW];

  for (genvar w = 0; w < NUM_EW; w++) begin : g_width
    localparam int unsigned EW = MIN_EW << w;
    localparam int unsigned IW = $clog2(VREG_W / EW);
    idx_fma_lanes #(.EW(EW)) u_lanes (
      .rn_v  (rf_val_n),
      .rm_v  (rf_val_m),
      .rd_v  (rf_val_d),
      .idx   (s1_dec.idx[IW-1:0]),
      .lanes (s1_dec.lanes),
      .neg   (s1_dec.neg),
      .mul_a (sh_a[w]),
      .mul_b (sh_b[w]),
      .acc   (sh_c[w])
    );
  end

  logic [VREG_W-1:0] sel_a, sel_b, sel_c;
  always_comb begin
    case (s1_dec.esz)
      ESZ_32:  begin sel_a = sh_a[1]; sel_b = sh_b[1]; sel_c = sh_c[1]; end
      ESZ_64:  begin sel_a = sh_a[2]; sel_b = sh_b[2]; sel_c = sh_c[2]; end
      default: begin sel_a = sh_a[0]; sel_b = sh_b[0]; sel_c = sh_c[0]; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_lanes <= '0;
      out_esz   <= '0;
      out_dst   <= '0;
      out_mul_a <= '0;
      out_mul_b <= '0;
      out_acc   <= '0;
    end else if (s2_free) begin
      out_valid <= s1_valid && !s1_bad;
      if (s1_valid && !s1_bad) begin
        out_lanes <= s1_dec.lanes;
        out_esz   <= s1_dec.esz;
        out_dst   <= s1_dec.dst;
        out_mul_a <= sel_a;
        out_mul_b <= sel_b;
        out_acc   <= sel_c;
      end
    end
  end
endmodule

// File: rtl/idx_fma_checks.sv
`timescale 1ns/1ps
module idx_fma_checks
  import idx_fma_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               out_valid,
  input logic               out_ready,
  input logic [LANE_CW-1:0] out_lanes,
  input logic [1:0]         out_esz,
  input logic [RIDX_W-1:0]  out_dst,
  input logic [VREG_W-1:0]  out_mul_a,
  input logic [VREG_W-1:0]  out_mul_b,
  input logic [VREG_W-1:0]  out_acc,
  input logic               out_undef,
  input logic               out_nomatch
);
  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_mul_a) && $stable(out_mul_b)
      && $stable(out_acc) && $stable(out_lanes) && $stable(out_dst) && $stable(out_esz));

  assert_flags_excl_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({out_undef, out_nomatch}));

  assert_lane_pow2_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $countones(out_lanes) == 1 && out_lanes <= LANE_CW'(MAX_LANES) && out_esz != 2'd3);

  assert_dbl_lanes_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_esz == 2'd2 |-> out_lanes <= LANE_CW'(2));

  assert_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_lanes == LANE_CW'(1) |->
      out_mul_a[VREG_W-1:VREG_W/2] == '0 && out_mul_b[VREG_W-1:VREG_W/2] == '0
      && out_acc[VREG_W-1:VREG_W/2] == '0);

  assert_bcast_R5: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_esz == 2'd1 && out_lanes == LANE_CW'(4) |->
      out_mul_b[31:0] == out_mul_b[127:96]);
endmodule

bind idx_fma_prep idx_fma_checks u_chk (
  .clk         (clk),
  .rst         (rst),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_lanes   (out_lanes),
  .out_esz     (out_esz),
  .out_dst     (out_dst),
  .out_mul_a   (out_mul_a),
  .out_mul_b   (out_mul_b),
  .out_acc     (out_acc),
  .out_undef   (out_undef),
  .out_nomatch (out_nomatch)
);

// File: tb/sim_idx_fma_prep.sv
`timescale 1ns/1ps
module sim_idx_fma_prep;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, fp16_en, in_valid, in_ready, out_valid, out_ready, out_undef, out_nomatch;
  logic [31:0] in_instr;
  logic [4:0] rf_idx_n, rf_idx_m, rf_idx_d, out_dst;
  logic [127:0] rf_val_n, rf_val_m, rf_val_d, out_mul_a, out_mul_b, out_acc;
  logic [3:0] out_lanes;
  logic [1:0] out_esz;
  int n_tests = 0;
  int n_fail = 0;

  idx_fma_prep u0 (
    .clk(clk), .rst(rst), .fp16_en(fp16_en), .in_valid(in_valid), .in_ready(in_ready),
    .in_instr(in_instr), .rf_idx_n(rf_idx_n), .rf_idx_m(rf_idx_m), .rf_idx_d(rf_idx_d),
    .rf_val_n(rf_val_n), .rf_val_m(rf_val_m), .rf_val_d(rf_val_d), .out_valid(out_valid),
    .out_ready(out_ready), .out_lanes(out_lanes), .out_esz(out_esz), .out_dst(out_dst),
    .out_mul_a(out_mul_a), .out_mul_b(out_mul_b), .out_acc(out_acc),
    .out_undef(out_undef), .out_nomatch(out_nomatch)
  );

  function automatic logic [127:0] rfv(input logic [4:0] r);
    logic [127:0] v;
    for (int j = 0; j < 8; j++) v[j*16 +: 16] = 16'(int'(r) * 256 + j * 16 + 5);
    return v;
  endfunction

  always_comb begin
    rf_val_n = rfv(rf_idx_n);
    rf_val_m = rfv(rf_idx_m);
    rf_val_d = rfv(rf_idx_d);
  end

  function automatic logic [31:0] mk(input bit sc, input bit q, input int prec, input bit sub,
                                     input bit h, input bit l, input bit m,
                                     input logic [3:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    logic [31:0] w = '0;
    w[30:24] = sc ? 7'b1011111 : {q, 6'b001111};
    w[23:22] = (prec == 0) ? 2'b00 : {1'b1, prec == 2};
    w[21] = l; w[20] = m; w[19:16] = rm; w[14] = sub; w[12] = 1'b1;
    w[11] = h; w[9:5] = rn; w[4:0] = rd;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic run_good(input string tag, input bit sc, input bit q, input int prec,
                          input bit sub, input bit h, input bit l, input bit m,
                          input logic [3:0] rm, input logic [4:0] rn, input logic [4:0] rd);
    int ew, idx, lanes;
    logic [4:0] mreg;
    logic [127:0] ea, eb, ec, rnv, rdv, mv;
    ew    = 16 << prec;
    idx   = (prec == 0) ? int'({h, l, m}) : (prec == 1) ? int'({h, l}) : int'(h);
    mreg  = (prec == 0) ? {1'b0, rm} : {m, rm};
    lanes = sc ? 1 : (q ? 128 : 64) / ew;
    rnv = rfv(rn); rdv = rfv(rd); mv = rfv(mreg) >> (idx * ew);
    ea = '0; eb = '0; ec = '0;
    for (int e = 0; e < lanes; e++)
      for (int k = 0; k < ew; k++) begin
        ea[e*ew+k] = rnv[e*ew+k] ^ (sub && k == ew - 1);
        eb[e*ew+k] = mv[k];
        ec[e*ew+k] = rdv[e*ew+k];
      end
    @(negedge clk);
    in_instr = mk(sc, q, prec, sub, h, l, m, rm, rn, rd);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!out_undef && !out_nomatch && !out_valid, "R10", {tag, " decode-cycle flags"},
        {out_valid, out_undef, out_nomatch}, 0);
    chk(rf_idx_m == mreg, "R4", {tag, " index reg"}, rf_idx_m, mreg);
    chk(rf_idx_n == rn, "R4", {tag, " first reg"}, rf_idx_n, rn);
    @(negedge clk);
    chk(out_valid === 1'b1, "R10", {tag, " valid"}, out_valid, 1);
    chk(out_lanes == 4'(lanes) && out_esz == 2'(prec), "R6", {tag, " lanes/esz"},
        {out_lanes, out_esz}, {4'(lanes), 2'(prec)});
    chk(out_dst == rd, "R4", {tag, " dst"}, out_dst, rd);
    chk(out_mul_a === ea, "R7", {tag, " mul_a (R8 upper zero)"}, out_mul_a, ea);
    chk(out_mul_b === eb, "R5", {tag, " broadcast (R8 upper zero)"}, out_mul_b, eb);
    chk(out_acc === ec, "R9", {tag, " acc (R8 upper zero)"}, out_acc, ec);
    @(negedge clk);
    chk(out_valid === 1'b0, "R10", {tag, " consumed"}, out_valid, 0);
  endtask

  task automatic run_bad(input string tag, input string req, input logic [31:0] w,
                         input bit e_undef, input bit e_nm);
    @(negedge clk);
    in_instr = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_undef == e_undef && out_nomatch == e_nm, req, {tag, " flags"},
        {out_undef, out_nomatch}, {e_undef, e_nm});
    @(negedge clk);
    chk(!out_undef && !out_nomatch && !out_valid, "R10", {tag, " flag one cycle, no valid"},
        {out_valid, out_undef, out_nomatch}, 0);
  endtask

  task automatic run_hold();
    logic [127:0] a0, b0;
    out_ready = 1'b0;
    @(negedge clk);
    in_instr = mk(0, 1, 1, 0, 0, 1, 0, 4'd6, 5'd1, 5'd2); in_valid = 1'b1;
    @(negedge clk);
    in_instr = mk(0, 1, 2, 1, 1, 0, 0, 4'd3, 5'd4, 5'd5);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1, "R11", "first bundle up", out_valid, 1);
    a0 = out_mul_a; b0 = out_mul_b;
    chk(in_ready === 1'b0, "R11", "in_ready low when full", in_ready, 0);
    repeat (3) @(negedge clk);
    chk(out_valid && out_mul_a === a0 && out_mul_b === b0 && out_dst == 5'd2,
        "R11", "bundle held", out_mul_a, a0);
    chk(in_ready === 1'b0, "R11", "in_ready still low", in_ready, 0);
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid && out_dst == 5'd5 && out_esz == 2'd2 && out_lanes == 4'd2,
        "R11", "second bundle after release", {out_dst, out_esz, out_lanes}, {5'd5, 2'd2, 4'd2});
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R11", "drained", {out_valid, in_ready}, 2'b01);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    rst = 1'b1; fp16_en = 1'b1; in_valid = 1'b0; in_instr = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !out_undef && !out_nomatch && in_ready, "R10", "reset state",
        {out_valid, out_undef, out_nomatch, in_ready}, 4'b0001);
    run_good("vec half 8 lanes idx5", 0, 1, 0, 0, 1, 0, 1, 4'd7, 5'd3, 5'd9);
    run_good("vec half 4 lanes sub", 0, 0, 0, 1, 0, 1, 0, 4'd12, 5'd20, 5'd31);
    run_good("scalar half M in index", 1, 0, 0, 0, 1, 1, 1, 4'd4, 5'd8, 5'd1);
    run_good("vec single 4 lanes M:Rm", 0, 1, 1, 0, 1, 1, 1, 4'd2, 5'd17, 5'd6);
    run_good("vec single 2 lanes sub", 0, 0, 1, 1, 0, 1, 0, 4'd9, 5'd11, 5'd12);
    run_good("vec double sub idx1", 0, 1, 2, 1, 1, 0, 1, 4'd15, 5'd25, 5'd26);
    run_good("scalar double", 1, 0, 2, 0, 0, 0, 0, 4'd5, 5'd2, 5'd30);
    run_good("scalar single sub", 1, 0, 1, 1, 1, 0, 0, 4'd1, 5'd14, 5'd0);
    fp16_en = 1'b0;
    run_bad("half disabled", "R2", mk(0, 1, 0, 0, 0, 0, 0, 4'd1, 5'd1, 5'd1), 1, 0);
    run_bad("scalar half disabled", "R2", mk(1, 0, 0, 1, 1, 1, 1, 4'd1, 5'd1, 5'd1), 1, 0);
    fp16_en = 1'b1;
    run_bad("double with L", "R3", mk(1, 0, 2, 0, 0, 1, 0, 4'd1, 5'd1, 5'd1), 1, 0);
    run_bad("vec double Q0", "R3", mk(0, 0, 2, 0, 0, 0, 0, 4'd1, 5'd1, 5'd1), 1, 0);
    w = mk(0, 1, 1, 0, 0, 0, 0, 4'd1, 5'd1, 5'd1); w[23:22] = 2'b01;
    run_bad("prec 01", "R1", w, 0, 1);
    w = mk(0, 1, 1, 0, 0, 0, 0, 4'd1, 5'd1, 5'd1); w[12] = 1'b0;
    run_bad("bit12 clear", "R1", w, 0, 1);
    w = mk(1, 0, 1, 0, 0, 0, 0, 4'd1, 5'd1, 5'd1); w[31] = 1'b1;
    run_bad("bit31 set", "R1", w, 0, 1);
    w = mk(0, 1, 1, 0, 0, 0, 0, 4'd1, 5'd1, 5'd1); w[10] = 1'b1;
    run_bad("bit10 set", "R1", w, 0, 1);
    run_hold();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule